// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional branch is taken. It receives the four arithmetic status flags and a 4-bit condition code. The flags are negative, zero, carry and overflow, as left behind by a compare or subtract, where carry means that no borrow occurred. Fourteen codes select equality, signed ordering, unsigned ordering and single-flag tests. The two remaining codes mean "always" and "never", so every code value has a defined meaning.

The evaluation is purely combinational. A one-stage output register captures the decision whenever the input strobe is high and presents it, with a valid flag, on the following cycle. Between strobes the register keeps the last decision, so a downstream sequencer can read it at any time. Signed tests are built from the relation between the negative and overflow flags, and unsigned tests from the carry flag. No magnitude comparator is involved.

The code space is arranged in pairs. The even member of each pair is a base test and the odd member is its complement. This lets a single small selection network serve all sixteen codes.

Top module: `branch_cond_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out_valid` is 0 and `taken` is 0.
- R2: Flag bits are `flags[3]`=N, `flags[2]`=Z, `flags[1]`=C, `flags[0]`=V. Code 0 is taken exactly when Z=1. Code 1 is taken exactly when Z=0.
- R3: Signed codes: 10 is taken when N==V, 11 when N!=V, 12 when Z==0 and N==V, and 13 when Z==1 or N!=V.
- R4: Unsigned codes: 2 is taken when C=1, 3 when C=0, 8 when C=1 and Z=0, and 9 when C=0 or Z=1.
- R5: Single-flag codes: 4 is taken when N=1, 5 when N=0, 6 when V=1, and 7 when V=0.
- R6: Code 14 is always taken and code 15 is never taken, whatever the flags are.
- R7: `out_valid` is 1 on exactly the cycle after a cycle with `in_valid`=1, and is 0 otherwise. `taken` then gives the decision for the flags and code sampled on that edge.
- R8: On cycles without `in_valid`, changes on `flags` and `cond` have no effect, and `taken` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: sample flags and cond this cycle |
| flags | input | 4 | Status flags {N, Z, C, V} |
| cond | input | 4 | Condition code, 0 to 15 |
| out_valid | output | 1 | Decision updated this cycle |
| taken | output | 1 | Branch decision, held between strobes |

## Verification
The hardest cases to reach are the flag combinations where the signed tests disagree with a naive reading of the sign. These are the cases with V=1, where "less than" must follow N!=V and not N alone. The cases where Z and N or C conflict also matter, because they separate the compound tests from their single-flag parts. The stimulus therefore sweeps all 256 pairs of flags and code back to back, so these rows occur next to every other code. Idle stretches are then inserted, during which the flags and code keep changing. This shows that the held decision ignores them.

// File: rtl/bcond_pkg.sv
package bcond_pkg;

    localparam int FLAG_W   = 4;
    localparam int COND_W   = 4;
    localparam int BASE_SEL = COND_W - 1;
    localparam int NUM_BASE = 1 << BASE_SEL;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef enum logic [COND_W-1:0] {
        CC_EQ = 4'd0,  CC_NE = 4'd1,
        CC_HS = 4'd2,  CC_LO = 4'd3,
        CC_MI = 4'd4,  CC_PL = 4'd5,
        CC_VS = 4'd6,  CC_VC = 4'd7,
        CC_HI = 4'd8,  CC_LS = 4'd9,
        CC_GE = 4'd10, CC_LT = 4'd11,
        CC_GT = 4'd12, CC_LE = 4'd13,
        CC_AL = 4'd14, CC_NV = 4'd15
    } cond_e;

    typedef struct packed {
        logic valid;
        logic taken;
    } decision_t;

    // pair index: even/odd codes share one base test
    function automatic logic [BASE_SEL-1:0] pair_index(cond_e c);
        return c[COND_W-1:1];
    endfunction

    // odd member of a pair is the complement of the base test
    function automatic logic pair_invert(cond_e c);
        return c[0];
    endfunction

endpackage

// File: rtl/bcond_base_tests.sv
module bcond_base_tests
    import bcond_pkg::*;
(
    input  flags_t              f,
    output logic [NUM_BASE-1:0] base
);
    logic sgn_lt;

    always_comb begin
        sgn_lt  = f.n ^ f.v;
        base    = '0;
        base[0] = f.z;                    // equal
        base[1] = f.c;                    // higher or same
        base[2] = f.n;                    // minus
        base[3] = f.v;                    // overflow set
        base[4] = f.c & ~f.z;             // higher
        base[5] = ~sgn_lt;                // signed greater or equal
        base[6] = ~f.z & ~sgn_lt;         // signed greater
        base[7] = 1'b1;                   // always
    end
endmodule

// File: rtl/bcond_select.sv
module bcond_select
    import bcond_pkg::*;
(
    input  logic [NUM_BASE-1:0] base,
    input  cond_e               code,
    output logic                hit
);
    logic [BASE_SEL-1:0] idx;
    logic                inv;

    always_comb begin
        idx = pair_index(code);
        inv = pair_invert(code);
        hit = base[idx] ^ inv;
    end
endmodule

// File: rtl/bcond_hold_stage.sv
module bcond_hold_stage
    import bcond_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  logic      value,
    output decision_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.valid <= load;
            if (load) begin
                q.taken <= value;
            end
        end
    end
endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
    import bcond_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [FLAG_W-1:0] flags,
    input  logic [COND_W-1:0] cond,
    output logic              out_valid,
    output logic              taken
);
    flags_t              f_in;
    cond_e               code_in;
    logic [NUM_BASE-1:0] base_vec;
    logic                hit;
    decision_t           dec_q;

    assign f_in    = flags_t'(flags);
    assign code_in = cond_e'(cond);

    bcond_base_tests u_base (
        .f    (f_in),
        .base (base_vec)
    );

    bcond_select u_sel (
        .base (base_vec),
        .code (code_in),
        .hit  (hit)
    );

    bcond_hold_stage u_hold (
        .clk   (clk),
        .rst   (rst),
        .load  (in_valid),
        .value (hit),
        .q     (dec_q)
    );

    assign out_valid = dec_q.valid;
    assign taken     = dec_q.taken;
endmodule

// File: rtl/branch_cond_unit_chk.sv
module branch_cond_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [3:0] flags,
    input logic [3:0] cond,
    input logic       out_valid,
    input logic       taken
);
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(taken));

    a_r2_equal: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond == 4'd0) |=> (taken == $past(flags[2])));

    a_r3_signed_lt: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond == 4'd11) |=> (taken == ($past(flags[3]) ^ $past(flags[0]))));

    a_r4_unsigned_hi: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond == 4'd8) |=> (taken == ($past(flags[1]) && !$past(flags[2]))));

    a_r5_minus: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond == 4'd4) |=> (taken == $past(flags[3])));

    a_r6_always: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond == 4'd14) |=> taken);

    a_r6_never: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond == 4'd15) |=> !taken);
endmodule

bind branch_cond_unit branch_cond_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .flags     (flags),
    .cond      (cond),
    .out_valid (out_valid),
    .taken     (taken)
);

// File: tb/branch_cond_unit_test.sv
module branch_cond_unit_test;

    typedef struct {
        logic [3:0] cond;
        logic [3:0] flags;
        logic       exp;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [3:0] flags = 4'd0;
    logic [3:0] cond = 4'd0;
    logic       out_valid;
    logic       taken;

    int    total = 0;
    int    bad = 0;
    int    cycles = 0;
    bit    finished = 1'b0;
    logic  last_exp = 1'b0;
    item_t q[$];

    always #2 clk = ~clk;

    branch_cond_unit uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .flags     (flags),
        .cond      (cond),
        .out_valid (out_valid),
        .taken     (taken)
    );

    // expected decision from the requirement text
    function automatic logic ref_taken(logic [3:0] c, logic [3:0] fl);
        logic n, z, cy, v;
        n = fl[3]; z = fl[2]; cy = fl[1]; v = fl[0];
        case (c)
            4'd0:  return z;                 // R2
            4'd1:  return !z;                // R2
            4'd2:  return cy;                // R4
            4'd3:  return !cy;               // R4
            4'd4:  return n;                 // R5
            4'd5:  return !n;                // R5
            4'd6:  return v;                 // R5
            4'd7:  return !v;                // R5
            4'd8:  return cy && !z;          // R4
            4'd9:  return !cy || z;          // R4
            4'd10: return n == v;            // R3
            4'd11: return n != v;            // R3
            4'd12: return !z && (n == v);    // R3
            4'd13: return z || (n != v);     // R3
            4'd14: return 1'b1;              // R6
            default: return 1'b0;            // R6
        endcase
    endfunction

    function automatic string req_tag(logic [3:0] c);
        case (c)
            4'd0, 4'd1:                     return "R2";
            4'd10, 4'd11, 4'd12, 4'd13:     return "R3";
            4'd2, 4'd3, 4'd8, 4'd9:         return "R4";
            4'd4, 4'd5, 4'd6, 4'd7:         return "R5";
            default:                        return "R6";
        endcase
    endfunction

    task automatic check(bit ok, string tag, logic act, logic exp, string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic send(logic [3:0] fl, logic [3:0] c);
        item_t it;
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        flags    = fl;
        cond     = c;
        it.cond  = c;
        it.flags = fl;
        it.exp   = ref_taken(c, fl);
        q.push_back(it);
    endtask

    task automatic idle(int n, int seed);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            in_valid = 1'b0;
            flags    = 4'((seed + i * 7) & 15);
            cond     = 4'((seed * 3 + i * 5) & 15);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        cycles++;
        if (rst) begin
            check(out_valid == 1'b0, "R1", out_valid, 1'b0, "out_valid in reset");
            check(taken == 1'b0, "R1", taken, 1'b0, "taken in reset");
        end else if (!finished) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R7", out_valid, 1'b0, "valid without request");
                end else begin
                    item_t it;
                    it = q.pop_front();
                    check(taken === it.exp, req_tag(it.cond), taken, it.exp,
                          $sformatf("cond=%0d flags=%b", it.cond, it.flags));
                    last_exp = it.exp;
                end
            end else begin
                check(taken === last_exp, "R8", taken, last_exp, "held decision while idle");
            end
        end
    end

    // watchdog
    initial begin
        wait (cycles > 100000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R1: first cycle out of reset still idle
        @(negedge clk);
        check(out_valid == 1'b0, "R1", out_valid, 1'b0, "out_valid after reset");
        check(taken == 1'b0, "R1", taken, 1'b0, "taken after reset");

        // R2..R6: exhaustive sweep, back to back (R7 one-cycle latency)
        for (int c = 0; c < 16; c++) begin
            for (int fl = 0; fl < 16; fl++) begin
                send(4'(fl), 4'(c));
            end
        end

        // R8: idle stretches with moving flags/code, after taken=1 and taken=0
        send(4'b0100, 4'd0);
        idle(6, 3);
        send(4'b0100, 4'd1);
        idle(6, 9);
        send(4'b1000, 4'd11);
        idle(4, 2);
        send(4'b1001, 4'd11);
        idle(4, 5);

        // R7: isolated requests with gaps, never codes interleaved
        for (int k = 0; k < 16; k++) begin
            send(4'((k * 5) & 15), 4'(15 - k));
            idle(k % 3, k);
        end
        idle(3, 1);

        // R7: every request produced exactly one result
        @(negedge clk);
        total++;
        if (q.size() != 0) begin
            bad++;
            $display("FAIL R7 pending results: actual=%0d expected=0", q.size());
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule